// File: doc/BRIEF.md
# Ripple-Synchronized Window Override

This block is the fast-transient path of a voltage-mode step-down controller. Beside the main PWM loop, two window comparators report whether the output is more than 3% under or over its setpoint. The flags are accepted only at one point of the inductor-current ripple each. The "under" flag is accepted where the on-time ends, which is the current peak. The "over" flag is accepted where the on-time begins, which is the current valley. So the output counts as low only when even its ripple peak is under the lower threshold. It counts as high only when even its ripple trough is over the upper threshold.

An accepted "under" flag arms a boost override, which holds the effective PWM at 100% duty. An accepted "over" flag arms a cut override, which holds it at 0% duty. An armed override stays in force until a reference-crossing flag shows that the output has passed through regulation. After that the main loop drives the effective PWM again. The block acts only once the soft-start stage asserts its window enable. A fault clears any override.

Edges of the main PWM signal are found against a registered copy of that signal. After reset the copy holds 0.

Top module: `ripple_override`

## Requirements
- R1: While reset is held and right after it, `boost_on` and `cut_on` are 0 and `pwm_eff` equals `pwm_main` in the same cycle.
- R2: In a cycle where `pwm_main` is 0 and was 1 in the previous cycle (the on-time ends), with `win_en`=1, `fault`=0 and `under_win`=1, the next clock sets `boost_on`=1.
- R3: In a cycle where `pwm_main` is 1 and was 0 in the previous cycle (the on-time starts; the previous value counts as 0 just after reset), with `win_en`=1, `fault`=0 and `over_win`=1, the next clock sets `cut_on`=1.
- R4: `under_win` has no effect outside a falling edge of `pwm_main`, and `over_win` has none outside a rising edge. In those cycles, without `ref_cross`, the override state is kept.
- R5: `boost_on`=1 forces `pwm_eff`=1, and `cut_on`=1 forces `pwm_eff`=0. With neither active, `pwm_eff` follows `pwm_main` combinationally.
- R6: `boost_on` and `cut_on` are never both 1. A capture of one override clears the other on the same clock.
- R7: `ref_cross`=1 in a cycle without a qualifying capture clears any active override at the next clock.
- R8: When `ref_cross` coincides with a qualifying capture, the capture wins (parameter `CAPTURE_WINS`=1, the default). With `CAPTURE_WINS`=0 the release wins.
- R9: `fault`=1 clears both overrides at the next clock and blocks any capture in that cycle.
- R10: `win_en`=0 clears both overrides at the next clock and blocks any capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_en | input | 1 | Window enable from soft-start |
| fault | input | 1 | Fault indication, clears overrides |
| pwm_main | input | 1 | Main-loop PWM latch output |
| under_win | input | 1 | Output under lower window threshold |
| over_win | input | 1 | Output over upper window threshold |
| ref_cross | input | 1 | Output crossed the regulation reference |
| pwm_eff | output | 1 | Effective PWM to the driver logic |
| boost_on | output | 1 | 100% duty override active |
| cut_on | output | 1 | 0% duty override active |

## Verification
Two functions can fall in the same cycle. A peak or valley capture can coincide with a reference-crossing release, and the captures of opposite direction can be chained so that one replaces the other. The bench holds `ref_cross` high on the exact cycle of a qualifying falling or rising `pwm_main` edge, and it also lets random stimulus produce such coincidences. The flags one clock later are judged against a bench model in which capture takes priority over release. A capture issued while the opposite override is active must leave only the new override set.

// File: rtl/rso_pkg.sv
package rso_pkg;
   typedef enum logic [1:0] {
      OVR_IDLE = 2'b00,
      OVR_LOW  = 2'b01,
      OVR_HIGH = 2'b10
   } ovr_e;
endpackage

// File: rtl/rso_edge_detect.sv
module rso_edge_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic pwm_in,
   output logic on_start,
   output logic on_end
);
   logic pwm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pwm_q <= 1'b0;
      else        pwm_q <= pwm_in;
   end

   assign on_start = pwm_in & ~pwm_q;
   assign on_end   = ~pwm_in & pwm_q;
endmodule

// File: rtl/rso_window_latch.sv
module rso_window_latch
   import rso_pkg::*;
#(
   parameter int unsigned CAPTURE_WINS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic fault,
   input  logic on_start,
   input  logic on_end,
   input  logic under_win,
   input  logic over_win,
   input  logic ref_cross,
   output ovr_e state
);
   logic grab_low, grab_high;
   ovr_e nxt;

   assign grab_low  = on_end   & under_win;
   assign grab_high = on_start & over_win;

   generate
      if (CAPTURE_WINS != 0) begin : g_capture_first
         always_comb begin
            nxt = state;
            if (!arm || fault)  nxt = OVR_IDLE;
            else if (grab_low)  nxt = OVR_LOW;
            else if (grab_high) nxt = OVR_HIGH;
            else if (ref_cross) nxt = OVR_IDLE;
         end
      end else begin : g_release_first
         always_comb begin
            nxt = state;
            if (!arm || fault)  nxt = OVR_IDLE;
            else if (ref_cross) nxt = OVR_IDLE;
            else if (grab_low)  nxt = OVR_LOW;
            else if (grab_high) nxt = OVR_HIGH;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= OVR_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/rso_pwm_mux.sv
module rso_pwm_mux
   import rso_pkg::*;
(
   input  ovr_e state,
   input  logic pwm_in,
   output logic pwm_out,
   output logic low_act,
   output logic high_act
);
   always_comb begin
      low_act  = (state == OVR_LOW);
      high_act = (state == OVR_HIGH);
      unique case (state)
         OVR_LOW:  pwm_out = 1'b1;
         OVR_HIGH: pwm_out = 1'b0;
         default:  pwm_out = pwm_in;
      endcase
   end
endmodule

// File: rtl/ripple_override.sv
module ripple_override
   import rso_pkg::*;
#(
   parameter int unsigned CAPTURE_WINS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic win_en,
   input  logic fault,
   input  logic pwm_main,
   input  logic under_win,
   input  logic over_win,
   input  logic ref_cross,
   output logic pwm_eff,
   output logic boost_on,
   output logic cut_on
);
   generate
      if (CAPTURE_WINS > 1) begin : g_bad_param
         $error("CAPTURE_WINS must be 0 or 1");
      end
   endgenerate

   logic on_start, on_end;
   ovr_e ovr_state;

   rso_edge_detect u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwm_in   (pwm_main),
      .on_start (on_start),
      .on_end   (on_end)
   );

   rso_window_latch #(.CAPTURE_WINS(CAPTURE_WINS)) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm       (win_en),
      .fault     (fault),
      .on_start  (on_start),
      .on_end    (on_end),
      .under_win (under_win),
      .over_win  (over_win),
      .ref_cross (ref_cross),
      .state     (ovr_state)
   );

   rso_pwm_mux u_mux (
      .state    (ovr_state),
      .pwm_in   (pwm_main),
      .pwm_out  (pwm_eff),
      .low_act  (boost_on),
      .high_act (cut_on)
   );
endmodule

// File: rtl/rso_checker.sv
module rso_checker #(
   parameter int unsigned CAPTURE_WINS = 1
) (
   input logic clk,
   input logic rst_n,
   input logic win_en,
   input logic fault,
   input logic pwm_main,
   input logic under_win,
   input logic over_win,
   input logic ref_cross,
   input logic pwm_eff,
   input logic boost_on,
   input logic cut_on
);
   logic prev_pwm;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_pwm <= 1'b0;
      else        prev_pwm <= pwm_main;
   end

   logic ok, low_cap, high_cap;
   assign ok       = win_en && !fault;
   assign low_cap  = ok && prev_pwm && !pwm_main && under_win;
   assign high_cap = ok && !prev_pwm && pwm_main && over_win;

   a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(boost_on && cut_on));
   a_r5_boost_forces: assert property (@(posedge clk) disable iff (!rst_n)
      boost_on |-> pwm_eff);
   a_r5_cut_forces: assert property (@(posedge clk) disable iff (!rst_n)
      cut_on |-> !pwm_eff);
   a_r5_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (!boost_on && !cut_on) |-> (pwm_eff == pwm_main));
   a_r2_low_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (low_cap && (CAPTURE_WINS != 0 || !ref_cross)) |=> boost_on);
   a_r3_high_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (high_cap && (CAPTURE_WINS != 0 || !ref_cross)) |=> cut_on);
   a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_cross && !low_cap && !high_cap) |=> (!boost_on && !cut_on));
   a_r9_fault_clears: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> (!boost_on && !cut_on));
   a_r10_enable_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !win_en |=> (!boost_on && !cut_on));
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ok && !ref_cross && !low_cap && !high_cap) |=> ($stable(boost_on) && $stable(cut_on)));
endmodule

bind ripple_override rso_checker #(.CAPTURE_WINS(CAPTURE_WINS)) u_rso_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .win_en    (win_en),
   .fault     (fault),
   .pwm_main  (pwm_main),
   .under_win (under_win),
   .over_win  (over_win),
   .ref_cross (ref_cross),
   .pwm_eff   (pwm_eff),
   .boost_on  (boost_on),
   .cut_on    (cut_on)
);

// File: tb/test_ripple_override.sv
`timescale 1ns/1ps
module test_ripple_override;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic win_en = 1'b0, fault = 1'b0, pwm_main = 1'b0;
   logic under_win = 1'b0, over_win = 1'b0, ref_cross = 1'b0;
   logic pwm_eff, boost_on, cut_on;

   int n_tests = 0;
   int n_fail  = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ripple_override #(.CAPTURE_WINS(1)) i_ripple_override (
      .clk(clk), .rst_n(rst_n), .win_en(win_en), .fault(fault),
      .pwm_main(pwm_main), .under_win(under_win), .over_win(over_win),
      .ref_cross(ref_cross), .pwm_eff(pwm_eff), .boost_on(boost_on),
      .cut_on(cut_on)
   );

   // model state: 0 idle, 1 boost, 2 cut
   int m_state = 0;
   logic m_prev = 1'b0;
   string m_rule = "R4";

   function automatic int next_state(int cur, logic prev, logic en, logic flt,
                                     logic pwm, logic und, logic ovr, logic rc,
                                     output string rule);
      logic fell = prev && !pwm;
      logic rose = !prev && pwm;
      if (!en) begin rule = "R10"; return 0; end
      if (flt) begin rule = "R9"; return 0; end
      if (fell && und) begin rule = rc ? "R8" : (cur == 2 ? "R6" : "R2"); return 1; end
      if (rose && ovr) begin rule = rc ? "R8" : (cur == 1 ? "R6" : "R3"); return 2; end
      if (rc) begin rule = "R7"; return 0; end
      rule = "R4";
      return cur;
   endfunction

   function automatic logic exp_pwm(int st, logic pwm);
      return (st == 1) ? 1'b1 : (st == 2) ? 1'b0 : pwm;
   endfunction

   task automatic check(string req, string what, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic step(logic en, logic flt, logic pwm, logic und, logic ovr, logic rc);
      win_en = en; fault = flt; pwm_main = pwm;
      under_win = und; over_win = ovr; ref_cross = rc;
      m_state = next_state(m_state, m_prev, en, flt, pwm, und, ovr, rc, m_rule);
      m_prev = pwm;
      @(posedge clk);
      @(negedge clk);
      check(m_rule, "boost_on", boost_on, m_state == 1);
      check(m_rule, "cut_on", cut_on, m_state == 2);
      check("R6", "both active", boost_on && cut_on, 0);
      check("R5", "pwm_eff", pwm_eff, exp_pwm(m_state, pwm));
   endtask

   // R5: pwm_eff combinational during the held state
   task automatic probe_pwm(logic pwm);
      pwm_main = pwm;
      #1;
      check("R5", "pwm_eff probe", pwm_eff, exp_pwm(m_state, pwm));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      // R1 reset state
      @(negedge clk);
      pwm_main = 1'b1; #1;
      check("R1", "boost_on in reset", boost_on, 0);
      check("R1", "cut_on in reset", cut_on, 0);
      check("R1", "pwm_eff in reset hi", pwm_eff, 1);
      pwm_main = 1'b0; #1;
      check("R1", "pwm_eff in reset lo", pwm_eff, 0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      step(1, 0, 0, 0, 0, 0);
      check("R1", "boost_on after reset", boost_on, 0);

      // R2: peak capture of under flag
      step(1, 0, 1, 1, 0, 0);          // R4: under at rising edge ignored
      step(1, 0, 0, 1, 0, 0);          // falling edge -> boost
      probe_pwm(1'b0);
      step(1, 0, 0, 0, 1, 0);          // R4: over without edge ignored
      step(1, 0, 1, 0, 0, 0);          // R4 hold
      step(1, 0, 1, 0, 0, 1);          // R7 release
      // R3: valley capture of over flag
      step(1, 0, 0, 0, 1, 0);          // R4: over at falling edge ignored
      step(1, 0, 1, 0, 1, 0);          // rising edge -> cut
      probe_pwm(1'b1);
      // R6: replace cut with boost
      step(1, 0, 0, 1, 0, 0);
      // R6: replace boost with cut
      step(1, 0, 1, 0, 1, 0);
      // R8: capture coincides with release
      step(1, 0, 0, 1, 0, 1);
      step(1, 0, 1, 0, 1, 1);
      // R9: fault clears and blocks
      step(1, 1, 0, 1, 0, 0);
      step(1, 0, 1, 0, 0, 0);
      step(1, 1, 0, 1, 0, 0);
      // R10: enable low clears and blocks
      step(1, 0, 1, 0, 1, 0);
      step(0, 0, 0, 1, 0, 0);
      step(0, 0, 1, 0, 1, 0);

      // random phase
      for (int i = 0; i < 4000; i++) begin
         logic p;
         p = ($urandom_range(99) < 35) ? ~pwm_main : pwm_main;
         step($urandom_range(99) < 96,
              $urandom_range(99) < 3,
              p,
              $urandom_range(99) < 25,
              $urandom_range(99) < 25,
              $urandom_range(99) < 8);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule